// File: doc/BRIEF.md
# Transition-Coded Multi-Wire Bus Receiver

This block listens to a shared bus of two to four data wires on which information is carried only by changes of the wire vector. Every settled change of state is turned into a digit, the XOR of the new and the old vector. The digit is never zero. A fixed number of digits is then folded back into one group value of up to twelve bits. The first change of a frame gives the sender's priority. Every following group is either eleven payload bits, an out-of-band code or, for the last group of the frame, the check value. Payload bits are packed into bytes, most significant bit first.

Skew between the wires is filtered out: a new vector counts only once it has held for a programmable number of timer ticks. The end of a frame is detected by a programmable quiet period. At that point the block releases the final byte with a last flag. It then reports two results: whether the trailing group matches an 11-bit CRC over all earlier groups, and whether the frame was malformed. The wire vector must already be synchronised to the clock.

Top module: `xcb_rx`

## Requirements
- R1: A new wire vector is accepted only after it has differed from the accepted vector and stayed unchanged for `settle_ticks_i` timer ticks; any shorter excursion, including an intermediate state while the wires skew, produces no digit.
- R2: The first accepted change after idle starts a frame. It drives `prio_o` with the XOR of the new and old vectors, pulses `prio_valid_o` for one cycle, and adds nothing to the payload or to the CRC.
- R3: Each later digit d = new XOR old (1..2^N-1) is folded as value = value*(2^N-1) + (d-1). A group completes after 7 digits on 2 wires, 4 on 3 wires and 3 on 4 wires, with the first digit most significant.
- R4: A group value below 2048 appends its 11 bits to the payload, most significant first. Bytes are emitted on `byte_o`/`byte_valid_o` with the earliest bit in bit 7.
- R5: A group value from 2048 to 2175 appends the 7 bits (value-2048). A value from 2176 to 2186 discards the payload bits that do not yet fill a byte.
- R6: A group value above 2186, which is reachable on 3 or 4 wires, marks the frame as malformed.
- R7: A frame ends when `idle_ticks_i` ticks pass with no accepted change. `frame_end_o` then pulses for one cycle, and the final byte is emitted in that same cycle with `byte_last_o` set. Payload bits left over that do not fill a byte are dropped.
- R8: The last group of a frame is the check value. It is compared with a CRC built as follows: registers start at 0; each earlier group is shifted in as 12 bits, MSB first; the feedback is register bit 10 XOR the input bit, and when set it XORs polynomial 0x385 into the left-shifted register. `crc_err_o` is set on a mismatch.
- R9: A frame that ends with a partially filled digit group, or that holds no group after the priority, sets `frame_err_o`.
- R10: After reset all output valid flags, `prio_o`, `crc_err_o` and `frame_err_o` are 0.
- R11: `crc_err_o` and `frame_err_o` change only in the cycle in which `frame_end_o` is high, and hold their value until the next frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wires_i | input | WIRES | Synchronised bus wire vector |
| tick_i | input | 1 | Timer tick, one cycle per tick |
| settle_ticks_i | input | SET_W | Ticks a new vector must hold |
| idle_ticks_i | input | IDLE_W | Quiet ticks that end a frame |
| byte_o | output | 8 | Received payload byte |
| byte_valid_o | output | 1 | `byte_o` valid this cycle |
| byte_last_o | output | 1 | Byte is the last of its frame |
| prio_o | output | WIRES | Priority digit of the current frame |
| prio_valid_o | output | 1 | Pulse when a frame starts |
| frame_end_o | output | 1 | Pulse when a frame is closed |
| crc_err_o | output | 1 | Check value mismatch of last frame |
| frame_err_o | output | 1 | Last frame was malformed |

## Verification
A digit appears one cycle after the tick that completes its settle count. Its group appears one cycle later. The bytes of a group leave the block only after the next group has arrived, at one per cycle and through a one-byte hold. `frame_end_o` and the two result flags follow the last change by the idle period plus a cycle or two. The bench therefore holds every wire state for ten cycles and waits sixty cycles after a frame's final change. A monitor on the falling edge gathers bytes, priority pulses and frame ends. All comparisons are made only after that window, and the reset values are checked one falling edge after reset is released.

// File: rtl/xcb_pkg.sv
package xcb_pkg;
   localparam int GRP_W      = 12;
   localparam int CRC_W      = 11;
   localparam int DATA_TOP   = 2047;
   localparam int SHORT_TOP  = 2175;
   localparam int CODE_TOP   = 2186;

   function automatic int digits_for(input int wires);
      case (wires)
         2:       return 7;
         3:       return 4;
         default: return 3;
      endcase
   endfunction

   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                 input logic [GRP_W-1:0] v,
                                                 input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] r;
      logic             fb;
      r = c;
      for (int i = GRP_W-1; i >= 0; i--) begin
         fb = r[CRC_W-1] ^ v[i];
         r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
      return r;
   endfunction
endpackage

// File: rtl/xcb_settle.sv
module xcb_settle #(
   parameter int W     = 2,
   parameter int SET_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     wires_i,
   input  logic             tick_i,
   input  logic [SET_W-1:0] settle_i,
   output logic             dig_v_o,
   output logic [W-1:0]     dig_o
);
   localparam int CW = SET_W + 1;

   logic [W-1:0]     cand, cur;
   logic [SET_W-1:0] cnt;
   logic             reached;

   assign reached = ({1'b0, cnt} + CW'(1)) >= {1'b0, settle_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand    <= '0;
         cur     <= '0;
         cnt     <= '0;
         dig_v_o <= 1'b0;
         dig_o   <= '0;
      end else begin
         dig_v_o <= 1'b0;
         if (wires_i != cand) begin
            cand <= wires_i;
            cnt  <= '0;
         end else if (cand != cur && tick_i) begin
            if (reached) begin
               cur     <= cand;
               dig_o   <= cand ^ cur;
               dig_v_o <= 1'b1;
               cnt     <= '0;
            end else begin
               cnt <= cnt + SET_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/xcb_group.sv
module xcb_group #(
   parameter int W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_i,
   input  logic                       dig_v_i,
   input  logic [W-1:0]               dig_i,
   output logic                       grp_v_o,
   output logic [xcb_pkg::GRP_W-1:0]  grp_o,
   output logic                       part_o
);
   localparam int GW   = xcb_pkg::GRP_W;
   localparam int D    = xcb_pkg::digits_for(W);
   localparam int BASE = (1 << W) - 1;
   localparam int CW   = $clog2(D + 1);

   logic [GW-1:0] acc, nxt;
   logic [CW-1:0] cnt;

   generate
      if (BASE ** D > (1 << GW)) begin : g_too_wide
         $error("xcb_group: group value does not fit the group width");
      end
   endgenerate

   assign nxt    = GW'(acc * GW'(BASE)) + GW'(dig_i) - GW'(1);
   assign part_o = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         cnt     <= '0;
         grp_v_o <= 1'b0;
         grp_o   <= '0;
      end else begin
         grp_v_o <= 1'b0;
         if (clr_i) begin
            acc <= '0;
            cnt <= '0;
         end else if (dig_v_i) begin
            if (cnt == CW'(D - 1)) begin
               grp_o   <= nxt;
               grp_v_o <= 1'b1;
               acc     <= '0;
               cnt     <= '0;
            end else begin
               acc <= nxt;
               cnt <= cnt + CW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/xcb_unpack.sv
module xcb_unpack (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_i,
   input  logic                      in_v_i,
   input  logic [xcb_pkg::GRP_W-1:0] val_i,
   output logic                      byte_v_o,
   output logic [7:0]                byte_o,
   output logic                      drained_o
);
   localparam int AW = 24;
   localparam int NW = 5;

   logic [AW-1:0] acc;
   logic [NW-1:0] nb, nb_a;

   assign byte_v_o  = (nb >= NW'(8));
   assign drained_o = !byte_v_o;
   assign byte_o    = 8'(acc >> (nb - NW'(8)));
   assign nb_a      = byte_v_o ? nb - NW'(8) : nb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         nb  <= '0;
      end else if (clr_i) begin
         nb <= '0;
      end else if (in_v_i) begin
         if (val_i <= 12'(xcb_pkg::DATA_TOP)) begin
            acc <= (acc << 11) | AW'(val_i[10:0]);
            nb  <= nb_a + NW'(11);
         end else if (val_i <= 12'(xcb_pkg::SHORT_TOP)) begin
            acc <= (acc << 7) | AW'(val_i[6:0]);
            nb  <= nb_a + NW'(7);
         end else if (val_i <= 12'(xcb_pkg::CODE_TOP)) begin
            nb  <= nb_a & 5'b11000;
         end else begin
            nb  <= nb_a;
         end
      end else begin
         nb <= nb_a;
      end
   end
endmodule

// File: rtl/xcb_rx.sv
module xcb_rx #(
   parameter int               WIRES    = 2,
   parameter int               SET_W    = 8,
   parameter int               IDLE_W   = 12,
   parameter logic [10:0]      CRC_POLY = 11'h385
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIRES-1:0]  wires_i,
   input  logic              tick_i,
   input  logic [SET_W-1:0]  settle_ticks_i,
   input  logic [IDLE_W-1:0] idle_ticks_i,
   output logic [7:0]        byte_o,
   output logic              byte_valid_o,
   output logic              byte_last_o,
   output logic [WIRES-1:0]  prio_o,
   output logic              prio_valid_o,
   output logic              frame_end_o,
   output logic              crc_err_o,
   output logic              frame_err_o
);
   import xcb_pkg::*;

   generate
      if (WIRES < 2 || WIRES > 4) begin : g_bad_wires
         $error("xcb_rx: WIRES must be 2, 3 or 4");
      end
      if (SET_W < 1 || IDLE_W < 2) begin : g_bad_cnt
         $error("xcb_rx: counter widths too small");
      end
   endgenerate

   logic              dig_v;
   logic [WIRES-1:0]  dig;
   logic              grp_v, part;
   logic [GRP_W-1:0]  grp;
   logic              ub_v, drained;
   logic [7:0]        ub_byte;

   logic              in_frame;
   logic [IDLE_W-1:0] idle_cnt;
   logic [GRP_W-1:0]  pend;
   logic              pend_v;
   logic [CRC_W-1:0]  crc;
   logic              err_st;
   logic [7:0]        hold;
   logic              hold_v;
   logic              end_now;

   assign end_now = in_frame && (idle_cnt >= idle_ticks_i) && drained && !dig_v && !grp_v;

   xcb_settle #(.W(WIRES), .SET_W(SET_W)) u_settle (
      .clk(clk), .rst_n(rst_n), .wires_i(wires_i), .tick_i(tick_i),
      .settle_i(settle_ticks_i), .dig_v_o(dig_v), .dig_o(dig));

   xcb_group #(.W(WIRES)) u_group (
      .clk(clk), .rst_n(rst_n), .clr_i(end_now), .dig_v_i(dig_v && in_frame),
      .dig_i(dig), .grp_v_o(grp_v), .grp_o(grp), .part_o(part));

   xcb_unpack u_unpack (
      .clk(clk), .rst_n(rst_n), .clr_i(end_now), .in_v_i(grp_v && pend_v),
      .val_i(pend), .byte_v_o(ub_v), .byte_o(ub_byte), .drained_o(drained));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame     <= 1'b0;
         idle_cnt     <= '0;
         pend         <= '0;
         pend_v       <= 1'b0;
         crc          <= '0;
         err_st       <= 1'b0;
         hold         <= '0;
         hold_v       <= 1'b0;
         byte_o       <= '0;
         byte_valid_o <= 1'b0;
         byte_last_o  <= 1'b0;
         prio_o       <= '0;
         prio_valid_o <= 1'b0;
         frame_end_o  <= 1'b0;
         crc_err_o    <= 1'b0;
         frame_err_o  <= 1'b0;
      end else begin
         byte_valid_o <= 1'b0;
         byte_last_o  <= 1'b0;
         prio_valid_o <= 1'b0;
         frame_end_o  <= 1'b0;

         if (dig_v) begin
            idle_cnt <= '0;
            if (!in_frame) begin
               in_frame     <= 1'b1;
               prio_o       <= dig;
               prio_valid_o <= 1'b1;
               crc          <= '0;
               err_st       <= 1'b0;
               pend_v       <= 1'b0;
               hold_v       <= 1'b0;
            end
         end else if (in_frame && tick_i && idle_cnt < idle_ticks_i) begin
            idle_cnt <= idle_cnt + IDLE_W'(1);
         end

         if (grp_v) begin
            if (pend_v) crc <= crc_step(crc, pend, CRC_POLY);
            pend   <= grp;
            pend_v <= 1'b1;
            if (grp > 12'(CODE_TOP)) err_st <= 1'b1;
         end

         if (ub_v) begin
            if (hold_v) begin
               byte_o       <= hold;
               byte_valid_o <= 1'b1;
            end
            hold   <= ub_byte;
            hold_v <= 1'b1;
         end

         if (end_now) begin
            in_frame    <= 1'b0;
            frame_end_o <= 1'b1;
            crc_err_o   <= pend_v && (pend != {1'b0, crc});
            frame_err_o <= err_st || part || !pend_v;
            if (hold_v) begin
               byte_o       <= hold;
               byte_valid_o <= 1'b1;
               byte_last_o  <= 1'b1;
               hold_v       <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/xcb_rx_chk.sv
module xcb_rx_chk #(
   parameter int WIRES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_valid_o,
   input logic             byte_last_o,
   input logic [WIRES-1:0] prio_o,
   input logic             prio_valid_o,
   input logic             frame_end_o,
   input logic             crc_err_o,
   input logic             frame_err_o,
   input logic             in_frame
);
   // R7
   last_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_last_o |-> (byte_valid_o && frame_end_o));

   // R2
   prio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prio_valid_o |-> (prio_o != '0));

   // R2
   prio_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prio_valid_o |-> (in_frame && !$past(in_frame)));

   // R7
   end_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end_o |-> (!in_frame && $past(in_frame)));

   // R11
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end_o |-> ($stable(crc_err_o) && $stable(frame_err_o)));

   // R2
   prio_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(prio_valid_o && byte_valid_o));
endmodule

bind xcb_rx xcb_rx_chk #(.WIRES(WIRES)) u_chk (
   .clk(clk), .rst_n(rst_n), .byte_valid_o(byte_valid_o), .byte_last_o(byte_last_o),
   .prio_o(prio_o), .prio_valid_o(prio_valid_o), .frame_end_o(frame_end_o),
   .crc_err_o(crc_err_o), .frame_err_o(frame_err_o), .in_frame(in_frame));

// File: tb/sim_xcb_rx.sv
module sim_xcb_rx;
   localparam int POLY = 'h385;

   logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic [1:0] w2 = '0;
   logic [2:0] w3 = '0;
   logic [7:0] b0, b1;
   logic       bv0, bl0, pv0, fe0, ce0, fr0;
   logic       bv1, bl1, pv1, fe1, ce1, fr1;
   logic [1:0] pr0;
   logic [2:0] pr1;

   always #10 clk = ~clk;
   always @(posedge clk) tick <= ~tick;

   xcb_rx #(.WIRES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wires_i(w2), .tick_i(tick),
      .settle_ticks_i(8'd3), .idle_ticks_i(12'd12),
      .byte_o(b0), .byte_valid_o(bv0), .byte_last_o(bl0), .prio_o(pr0),
      .prio_valid_o(pv0), .frame_end_o(fe0), .crc_err_o(ce0), .frame_err_o(fr0));

   xcb_rx #(.WIRES(3)) u1 (
      .clk(clk), .rst_n(rst_n), .wires_i(w3), .tick_i(tick),
      .settle_ticks_i(8'd3), .idle_ticks_i(12'd12),
      .byte_o(b1), .byte_valid_o(bv1), .byte_last_o(bl1), .prio_o(pr1),
      .prio_valid_o(pv1), .frame_end_o(fe1), .crc_err_o(ce1), .frame_err_o(fr1));

   int errs = 0, checks = 0;
   bit done = 0;
   int gq[$], expb[$], gotb[$], gotl[$], pay[$];
   int ends0 = 0, ends1 = 0, pvs0 = 0, lastprio0 = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (bv0) begin gotb.push_back(int'(b0)); gotl.push_back(int'(bl0)); end
         if (pv0) begin pvs0++; lastprio0 = int'(pr0); end
         if (fe0) ends0++;
         if (fe1) ends1++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic put(input int sel, input int s);
      @(negedge clk);
      if (sel == 0) w2 = 2'(s); else w3 = 3'(s);
   endtask

   // R1: multi-wire changes pass through a one-cycle skew state
   task automatic send_digit(input int sel, input int d);
      int cur = (sel == 0) ? int'(w2) : int'(w3);
      if ($countones(d) > 1) put(sel, cur ^ (d & -d));
      put(sel, cur ^ d);
      repeat (9) @(negedge clk);
   endtask

   // R3: digits most significant first, digit = value + 1
   task automatic send_group(input int sel, input int g);
      int base = (sel == 0) ? 3 : 7;
      int nd = (sel == 0) ? 7 : 4;
      int t[7];
      for (int i = nd - 1; i >= 0; i--) begin t[i] = g % base; g = g / base; end
      for (int i = 0; i < nd; i++) send_digit(sel, t[i] + 1);
   endtask

   function automatic int crc_step(input int c, input int v);
      for (int i = 11; i >= 0; i--) begin
         int fb = ((c >> 10) ^ (v >> i)) & 1;
         c = (c << 1) & 'h7FF;
         if (fb != 0) c = c ^ POLY;
      end
      return c;
   endfunction

   task automatic encode();
      int acc = 0, nb = 0;
      gq.delete();
      foreach (pay[i]) begin
         acc = (acc << 8) | pay[i]; nb += 8;
         while (nb >= 11) begin
            gq.push_back((acc >> (nb - 11)) & 'h7FF);
            nb -= 11; acc &= (1 << nb) - 1;
         end
      end
      if (nb >= 8) gq.push_back((acc << (11 - nb)) & 'h7FF);
      else if (nb > 0) gq.push_back(2048 + ((acc << (7 - nb)) & 'h7F));
   endtask

   task automatic add_crc(input bit bad);
      int c = 0;
      foreach (gq[i]) c = crc_step(c, gq[i]);
      gq.push_back(bad ? (c ^ 1) : c);
   endtask

   task automatic model();
      int acc = 0, nb = 0;
      expb.delete();
      for (int i = 0; i < gq.size() - 1; i++) begin
         int g = gq[i];
         if (g < 2048) begin acc = (acc << 11) | g; nb += 11; end
         else if (g < 2176) begin acc = (acc << 7) | (g - 2048); nb += 7; end
         else if (g <= 2186) nb = nb & ~7;
         while (nb >= 8) begin
            expb.push_back((acc >> (nb - 8)) & 255);
            nb -= 8; acc &= (1 << nb) - 1;
         end
      end
   endtask

   task automatic run_frame0(input int p, input bit bad, input string tag);
      gotb.delete(); gotl.delete(); ends0 = 0; pvs0 = 0;
      model();
      send_digit(0, p);
      foreach (gq[i]) send_group(0, gq[i]);
      repeat (60) @(negedge clk);
      chk(ends0 == 1, {tag, " R7 frame end count"}, ends0, 1);
      chk(pvs0 == 1 && lastprio0 == p, {tag, " R2 priority"}, lastprio0, p);
      chk(gotb.size() == expb.size(), {tag, " R4 byte count"}, gotb.size(), expb.size());
      for (int i = 0; i < gotb.size() && i < expb.size(); i++) begin
         chk(gotb[i] == expb[i], {tag, " R4 R5 byte value"}, gotb[i], expb[i]);
         chk(gotl[i] == int'(i == gotb.size() - 1), {tag, " R7 last flag"}, gotl[i], int'(i == gotb.size() - 1));
      end
      chk(ce0 == bad, {tag, " R8 crc flag"}, int'(ce0), int'(bad));
      chk(fr0 == 0, {tag, " R9 frame flag"}, int'(fr0), 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10
      chk(!bv0 && !pv0 && !fe0, "R10 valid flags after reset", int'({bv0, pv0, fe0}), 0);
      chk(!ce0 && !fr0 && pr0 == 0, "R10 result flags after reset", int'({ce0, fr0, pr0}), 0);
      repeat (5) @(negedge clk);

      // R1: glitch shorter than the settle time
      pvs0 = 0; ends0 = 0;
      put(0, int'(w2) ^ 3); repeat (2) @(negedge clk); put(0, int'(w2) ^ 3);
      repeat (80) @(negedge clk);
      chk(pvs0 == 0 && ends0 == 0, "R1 glitch ignored", pvs0 + ends0, 0);

      pay = '{8'h3C}; encode(); add_crc(0); run_frame0(1, 0, "one byte");
      pay = '{8'hA5, 8'h5A}; encode(); add_crc(0); run_frame0(3, 0, "short code");

      for (int k = 0; k < 10; k++) begin
         int len = $urandom_range(1, 8);
         pay.delete();
         for (int j = 0; j < len; j++) pay.push_back($urandom_range(0, 255));
         encode(); add_crc(0);
         run_frame0($urandom_range(1, 3), 0, "random");
      end

      // R5: discard code drops the partial byte
      gq = '{'h5A3, 2176, 'h2F1}; add_crc(0);
      run_frame0(2, 0, "discard code");
      chk(expb.size() == 2 && gotb.size() == 2 && gotb[1] == 'h5E, "R5 discard result", gotb.size(), 2);

      // R8: corrupted check value
      pay = '{8'hA5, 8'h3C}; encode(); add_crc(1); run_frame0(2, 1, "bad crc");

      // R11 and R9: flags hold during the next frame; priority-only frame
      ends0 = 0;
      send_digit(0, 1);
      repeat (5) @(negedge clk);
      chk(ce0 == 1, "R11 crc flag held", int'(ce0), 1);
      repeat (60) @(negedge clk);
      chk(ends0 == 1 && fr0 == 1, "R9 priority-only frame", int'(fr0), 1);
      chk(ce0 == 0, "R8 no check value no crc flag", int'(ce0), 0);

      // R9: partial digit group
      gotb.delete(); ends0 = 0;
      send_digit(0, 2); send_digit(0, 1); send_digit(0, 3); send_digit(0, 2);
      repeat (60) @(negedge clk);
      chk(ends0 == 1 && fr0 == 1, "R9 partial group", int'(fr0), 1);
      chk(gotb.size() == 0, "R9 no bytes", gotb.size(), 0);

      // R6: out-of-range group on three wires
      gq = '{2400}; add_crc(0); ends1 = 0;
      send_digit(1, 5);
      foreach (gq[i]) send_group(1, gq[i]);
      repeat (60) @(negedge clk);
      chk(ends1 == 1 && fr1 == 1, "R6 value above top code", int'(fr1), 1);
      chk(ce1 == 0, "R8 three-wire crc", int'(ce1), 0);
      gq = '{291}; add_crc(0); ends1 = 0;
      send_digit(1, 6);
      foreach (gq[i]) send_group(1, gq[i]);
      repeat (60) @(negedge clk);
      chk(ends1 == 1 && fr1 == 0 && ce1 == 0, "R6 R3 valid three-wire frame", int'({fr1, ce1}), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule